// File: doc/BRIEF.md
# NAND Flash Bus Cycle Controller

This block connects a simple 32-bit register port to an 8-bit asynchronous NAND flash bus. Software sends command bytes and address bytes to two separate registers. Each such write produces one bus cycle, with the command latch or the address latch line raised for the whole cycle. Accesses to the data register produce byte-wide data cycles. A configuration bit sets the direction of these data cycles.

Every bus cycle has three phases: a setup phase, a strobe phase in which the write or read strobe is held low, and a hold phase. The length of each phase comes from a 4-bit count in the timing register. Reads and writes have their own sets of counts.

The block also handles the following:
- A ready-wait window delays the watch on the ready/busy pin after a command or read cycle.
- A chip-enable override holds the flash selected between cycles.
- A transfer counter marks the end of a run of data cycles.
- Two interrupt sources are provided, each with an enable bit and a write-one-to-clear bit.

Top module: `nand_cycle_ctrl`

## Requirements
- R1: After reset, chip-enable and both strobes are high. Both latch lines and the data drive enable are low. Every readable register reads 0 and the interrupt output is low. Word indices: 0 data, 1 address, 2 command, 3 control, 4 configuration, 5 status, 6 interrupt status, 7 interrupt enable, 8 interrupt clear, 9 timing, 10 transfer count. Unmapped indices read 0.
- R2: The timing register reads back as written. Its read fields are setup [3:0], hold [7:4], strobe [11:8] and ready-wait [15:12]. Its write fields are setup [19:16], hold [23:20], strobe [27:24] and ready-wait [31:28].
- R3: While a cycle runs, chip-enable is low. The cycle spends setup+1 clocks with the strobe high, then strobe+1 clocks with the strobe low, then hold+1 clocks with the strobe high, and then releases chip-enable. Command, address and write cycles use the write fields. Read cycles use the read fields.
- R4: A write to the command register starts a cycle with the command latch high, the address latch low, the write strobe pulsed, and the data bus driven with the low byte of the written value.
- R5: A write to the address register starts the same kind of cycle with the address latch high instead of the command latch.
- R6: With configuration bit 1 clear, a write to the data register starts a write cycle. Both latches are low and the low byte is driven for the whole cycle. Between cycles, the data output keeps the byte of the last cycle started.
- R7: With configuration bit 1 set, a read of the data register starts a read cycle with the read strobe and with the bus not driven. The read itself returns, in bits [7:0], the byte sampled on the final strobe clock of the previous read cycle.
- R8: While a cycle runs, status bit 1 reads 1. Data, command and address accesses made during a cycle start nothing and leave the data output unchanged.
- R9: Configuration bit 5 set holds chip-enable low while no cycle runs. When the bit is clear, chip-enable is high between cycles.
- R10: Writing 1 to control bit 2 returns every register and sequencer to its reset state. The bit reads 0.
- R11: Status bit 0 follows the ready pin (1 = ready) after a two-flop synchroniser.
- R12: When a command or read cycle ends, a window of ready-wait+1 clocks starts. After the window, the next low-to-high change of the ready pin sets interrupt status bit 0. A rise that falls inside the window is ignored. Before any command or read cycle, a rise sets nothing.
- R13: Writing the transfer count register loads it. Each completed data cycle lowers it by one, and it stops at 0. The step from 1 to 0 sets interrupt status bit 1.
- R14: Writing 1 to a bit of the interrupt clear register clears that status bit. The interrupt output is high when any status bit is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| nand_ce_n | output | 1 | Flash chip-enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rdy | input | 1 | Ready/busy pin, 1 = ready |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take two things for granted:
- A register write and a register read never occur in the same clock.
- The flash drives `nand_dq_in` stable through the whole strobe phase of a read cycle.

The ready pin is treated as asynchronous, so no assertion depends on the exact clock in which it changes.

The stimulus keeps within these limits in three ways:
- It raises one access strobe at a time, and for one clock only.
- It sets the input byte before starting each read.
- It changes the ready pin only on falling clock edges, at spacings much longer than the synchroniser delay.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  localparam int FIELD_W = 4;
  localparam int BUS_W   = 8;

  localparam int IDX_DATA = 0;
  localparam int IDX_ADDR = 1;
  localparam int IDX_CMD  = 2;
  localparam int IDX_CTRL = 3;
  localparam int IDX_CFG  = 4;
  localparam int IDX_STAT = 5;
  localparam int IDX_IST  = 6;
  localparam int IDX_IEN  = 7;
  localparam int IDX_ICLR = 8;
  localparam int IDX_TIM  = 9;
  localparam int IDX_CNT  = 10;

  typedef enum logic [1:0] {K_CMD, K_ADDR, K_WR, K_RD} kind_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  typedef struct packed {
    logic [FIELD_W-1:0] rdy_wait;
    logic [FIELD_W-1:0] strobe;
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] setup;
  } tim_t;

  typedef struct packed {
    tim_t wr;
    tim_t rd;
  } tim_pair_t;
endpackage

// File: rtl/nbc_cycle_seq.sv
module nbc_cycle_seq
  import nbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  kind_e            start_kind,
  input  logic [BUS_W-1:0] start_byte,
  input  tim_t             start_tim,
  input  logic [BUS_W-1:0] dq_in,
  output logic             busy,
  output logic             done,
  output kind_e            done_kind,
  output logic [BUS_W-1:0] rd_byte,
  output logic [BUS_W-1:0] dq_out,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic             dq_oe
);
  phase_e             ph_q, ph_d;
  logic [FIELD_W-1:0] cnt_q, cnt_d;
  kind_e              kind_q;
  logic [BUS_W-1:0]   byte_q;
  logic [BUS_W-1:0]   rd_q;
  tim_t               tim_q;
  logic               load_en;
  logic               cap_en;
  logic               last;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    last  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_SETUP;
          cnt_d = '0;
        end
      end
      PH_SETUP: begin
        if (cnt_q == tim_q.setup) begin
          ph_d  = PH_STROBE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_q == tim_q.strobe) begin
          ph_d  = PH_HOLD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == tim_q.hold) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
          last  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  assign load_en = (ph_q == PH_IDLE) && start;
  assign cap_en  = (ph_q == PH_STROBE) && (cnt_q == tim_q.strobe) && (kind_q == K_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (clr) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_CMD;
      byte_q <= '0;
      tim_q  <= '0;
    end else if (clr) begin
      kind_q <= K_CMD;
      byte_q <= '0;
      tim_q  <= '0;
    end else if (load_en) begin
      kind_q <= start_kind;
      byte_q <= start_byte;
      tim_q  <= start_tim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (clr) begin
      rd_q <= '0;
    end else if (cap_en) begin
      rd_q <= dq_in;
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign done      = last;
  assign done_kind = kind_q;
  assign rd_byte   = rd_q;
  assign dq_out    = byte_q;
  assign cle       = busy && (kind_q == K_CMD);
  assign ale       = busy && (kind_q == K_ADDR);
  assign we_n      = !((ph_q == PH_STROBE) && (kind_q != K_RD));
  assign re_n      = !((ph_q == PH_STROBE) && (kind_q == K_RD));
  assign dq_oe     = busy && (kind_q != K_RD);

  // R3
  setup_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SETUP) |-> (cnt_q <= tim_q.setup));

  // R3
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_STROBE) && !clr) |=> ((ph_q == PH_STROBE) || (ph_q == PH_HOLD)));

  // R8
  launch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q != PH_IDLE) && !clr) |=> ($stable(byte_q) && $stable(kind_q)));
endmodule

// File: rtl/nbc_rdy_watch.sv
module nbc_rdy_watch
  import nbc_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               rdy_pin,
  input  logic               arm,
  input  logic [FIELD_W-1:0] arm_wait,
  output logic               rdy_sync,
  output logic               evt
);
  logic [SYNC_N-1:0]  sync_q;
  logic               prev_q;
  logic               waiting_q, waiting_d;
  logic               armed_q, armed_d;
  logic [FIELD_W-1:0] wcnt_q, wcnt_d;
  logic               rise;

  generate
    if (SYNC_N == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sync_q <= '0;
        else if (clr) sync_q <= '0;
        else          sync_q <= rdy_pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sync_q <= '0;
        else if (clr) sync_q <= '0;
        else          sync_q <= {sync_q[SYNC_N-2:0], rdy_pin};
      end
    end
  endgenerate

  assign rdy_sync = sync_q[SYNC_N-1];
  assign rise     = rdy_sync && !prev_q;

  always_comb begin
    waiting_d = waiting_q;
    armed_d   = armed_q;
    wcnt_d    = wcnt_q;
    if (arm) begin
      waiting_d = 1'b1;
      armed_d   = 1'b0;
      wcnt_d    = arm_wait;
    end else if (waiting_q) begin
      if (wcnt_q == '0) begin
        waiting_d = 1'b0;
        armed_d   = 1'b1;
      end else begin
        wcnt_d = wcnt_q - 1'b1;
      end
    end else if (armed_q && rise) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      waiting_q <= 1'b0;
      armed_q   <= 1'b0;
      wcnt_q    <= '0;
    end else if (clr) begin
      prev_q    <= 1'b0;
      waiting_q <= 1'b0;
      armed_q   <= 1'b0;
      wcnt_q    <= '0;
    end else begin
      prev_q    <= rdy_sync;
      waiting_q <= waiting_d;
      armed_q   <= armed_d;
      wcnt_q    <= wcnt_d;
    end
  end

  assign evt = armed_q && rise && !arm;

  // R12
  evt_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

// File: rtl/nbc_xfer_cnt.sv
module nbc_xfer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (load)
      count_d = load_val;
    else if (step && (count_q != '0))
      count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (clr) count_q <= '0;
    else          count_q <= count_d;
  end

  assign count = count_q;
  assign hit   = step && !load && (count_q == ONE);

  // R13
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && (count_q == '0)) |=> (count_q == '0));

  // R13
  hit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (count_q == '0));
endmodule

// File: rtl/nand_cycle_ctrl.sv
module nand_cycle_ctrl
  import nbc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_in,
  input  logic              nand_rdy,
  output logic              irq
);
  logic      ce_force_q, ce_force_d;
  logic      dir_rd_q, dir_rd_d;
  tim_pair_t tim_q, tim_d;
  logic [1:0] ien_q, ien_d;
  logic [1:0] ist_q, ist_d;

  logic sel_data, sel_addr, sel_cmd, sel_ctrl, sel_cfg, sel_iclr, sel_ien, sel_tim, sel_cnt;
  logic soft_clr;
  logic go_cmd, go_adr, go_wr, go_rd, start;
  kind_e start_kind;
  tim_t  start_tim;

  logic             busy, done;
  kind_e            done_kind;
  logic [BUS_W-1:0] rd_byte;
  logic             rdy_sync, rdy_evt, arm;
  logic [FIELD_W-1:0] arm_wait;
  logic [CNT_W-1:0] count;
  logic             tc_hit, tc_step;

  always_comb begin
    sel_data = (reg_addr == ADDR_W'(IDX_DATA));
    sel_addr = (reg_addr == ADDR_W'(IDX_ADDR));
    sel_cmd  = (reg_addr == ADDR_W'(IDX_CMD));
    sel_ctrl = (reg_addr == ADDR_W'(IDX_CTRL));
    sel_cfg  = (reg_addr == ADDR_W'(IDX_CFG));
    sel_iclr = (reg_addr == ADDR_W'(IDX_ICLR));
    sel_ien  = (reg_addr == ADDR_W'(IDX_IEN));
    sel_tim  = (reg_addr == ADDR_W'(IDX_TIM));
    sel_cnt  = (reg_addr == ADDR_W'(IDX_CNT));
  end

  assign soft_clr = reg_wr && sel_ctrl && reg_wdata[2];

  // Launch decode: bus accesses only take effect while the sequencer is idle
  assign go_cmd = reg_wr && sel_cmd  && !busy;
  assign go_adr = reg_wr && sel_addr && !busy;
  assign go_wr  = reg_wr && sel_data && !dir_rd_q && !busy;
  assign go_rd  = reg_rd && sel_data &&  dir_rd_q && !busy;
  assign start  = go_cmd || go_adr || go_wr || go_rd;

  always_comb begin
    if (go_rd)       start_kind = K_RD;
    else if (go_wr)  start_kind = K_WR;
    else if (go_adr) start_kind = K_ADDR;
    else             start_kind = K_CMD;
    start_tim = go_rd ? tim_q.rd : tim_q.wr;
  end

  always_comb begin
    ce_force_d = ce_force_q;
    dir_rd_d   = dir_rd_q;
    tim_d      = tim_q;
    ien_d      = ien_q;
    if (reg_wr && sel_cfg) begin
      ce_force_d = reg_wdata[5];
      dir_rd_d   = reg_wdata[1];
    end
    if (reg_wr && sel_tim) tim_d = reg_wdata;
    if (reg_wr && sel_ien) ien_d = reg_wdata[1:0];
    ist_d = ist_q;
    if (reg_wr && sel_iclr) ist_d = ist_d & ~reg_wdata[1:0];
    ist_d = ist_d | {tc_hit, rdy_evt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_force_q <= 1'b0;
      dir_rd_q   <= 1'b0;
      tim_q      <= '0;
      ien_q      <= '0;
      ist_q      <= '0;
    end else if (soft_clr) begin
      ce_force_q <= 1'b0;
      dir_rd_q   <= 1'b0;
      tim_q      <= '0;
      ien_q      <= '0;
      ist_q      <= '0;
    end else begin
      ce_force_q <= ce_force_d;
      dir_rd_q   <= dir_rd_d;
      tim_q      <= tim_d;
      ien_q      <= ien_d;
      ist_q      <= ist_d;
    end
  end

  nbc_cycle_seq i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (soft_clr),
    .start      (start),
    .start_kind (start_kind),
    .start_byte (reg_wdata[BUS_W-1:0]),
    .start_tim  (start_tim),
    .dq_in      (nand_dq_in),
    .busy       (busy),
    .done       (done),
    .done_kind  (done_kind),
    .rd_byte    (rd_byte),
    .dq_out     (nand_dq_out),
    .cle        (nand_cle),
    .ale        (nand_ale),
    .we_n       (nand_we_n),
    .re_n       (nand_re_n),
    .dq_oe      (nand_dq_oe)
  );

  assign arm      = done && ((done_kind == K_CMD) || (done_kind == K_RD));
  assign arm_wait = (done_kind == K_RD) ? tim_q.rd.rdy_wait : tim_q.wr.rdy_wait;

  nbc_rdy_watch #(.SYNC_N(SYNC_N)) i_rdy (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_clr),
    .rdy_pin  (nand_rdy),
    .arm      (arm),
    .arm_wait (arm_wait),
    .rdy_sync (rdy_sync),
    .evt      (rdy_evt)
  );

  assign tc_step = done && ((done_kind == K_WR) || (done_kind == K_RD));

  nbc_xfer_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_clr),
    .load     (reg_wr && sel_cnt),
    .load_val (reg_wdata[CNT_W-1:0]),
    .step     (tc_step),
    .count    (count),
    .hit      (tc_hit)
  );

  assign nand_ce_n = !(busy || ce_force_q);
  assign irq       = |(ist_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(IDX_DATA): reg_rdata = 32'(rd_byte);
      ADDR_W'(IDX_CFG):  reg_rdata = {26'd0, ce_force_q, 3'd0, dir_rd_q, 1'b0};
      ADDR_W'(IDX_STAT): reg_rdata = {30'd0, busy, rdy_sync};
      ADDR_W'(IDX_IST):  reg_rdata = {30'd0, ist_q};
      ADDR_W'(IDX_IEN):  reg_rdata = {30'd0, ien_q};
      ADDR_W'(IDX_TIM):  reg_rdata = tim_q;
      ADDR_W'(IDX_CNT):  reg_rdata = 32'(count);
      default:           reg_rdata = '0;
    endcase
  end

  // R10
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> ((tim_q == '0) && (ien_q == '0) && !ce_force_q && !busy));

  // R14
  ist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel_iclr && reg_wdata[1] && !tc_hit) |=> !ist_q[1]);

  // R4
  cmd_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_cmd && !soft_clr) |=> (nand_cle && !nand_ale && !nand_ce_n));
endmodule

// File: tb/test_nand_cycle_ctrl.sv
module test_nand_cycle_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out, nand_dq_in;
  logic        nand_rdy, irq;

  int n_tot = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  nand_cycle_ctrl i_nand_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rdy(nand_rdy),
    .irq(irq)
  );

  localparam logic [3:0] A_DATA = 0, A_ADDR = 1, A_CMD = 2, A_CTRL = 3, A_CFG = 4,
                         A_STAT = 5, A_IST = 6, A_IEN = 7, A_ICLR = 8, A_TIM = 9, A_CNT = 10;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic [31:0] mk(input int ws, wh, ww, wr, rs, rh, rw, rr);
    return {4'(wr), 4'(ww), 4'(wh), 4'(ws), 4'(rr), 4'(rw), 4'(rh), 4'(rs)};
  endfunction

  function automatic int fv(input int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 3;
      default: return 15;
    endcase
  endfunction

  // Observes one bus cycle, starting at the falling edge just after launch
  task automatic run_cycle(input bit is_rd, input logic ecle, input logic eale,
                           input logic [7:0] eb, output int s, output int w,
                           output int h, output int bad);
    s = 0; w = 0; h = 0; bad = 0;
    for (int i = 0; i < 200; i++) begin
      logic stb, oth;
      if (nand_ce_n) break;
      stb = is_rd ? !nand_re_n : !nand_we_n;
      oth = is_rd ? !nand_we_n : !nand_re_n;
      if (oth || nand_cle !== ecle || nand_ale !== eale || nand_dq_oe !== !is_rd ||
          (!is_rd && nand_dq_out !== eb))
        bad++;
      if (stb) w++;
      else if (w == 0) s++;
      else h++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tot++; n_bad++;
    $display("FAIL watchdog R1 actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int s, w, h, bad;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    nand_dq_in = 8'h00; nand_rdy = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ce_n", nand_ce_n, 1);
    chk("R1 we_n/re_n", {nand_we_n, nand_re_n}, 2'b11);
    chk("R1 cle/ale/oe", {nand_cle, nand_ale, nand_dq_oe}, 3'b000);
    chk("R1 irq", irq, 0);
    rd_reg(A_CFG, d);  chk("R1 cfg", d, 0);
    rd_reg(A_TIM, d);  chk("R1 tim", d, 0);
    rd_reg(A_IST, d);  chk("R1 ist", d, 0);
    rd_reg(A_CNT, d);  chk("R1 cnt", d, 0);
    rd_reg(4'd13, d);  chk("R1 unmapped", d, 0);

    // R2 field layout read-back
    wr_reg(A_TIM, 32'h9A5C_3E71);
    rd_reg(A_TIM, d);  chk("R2 tim readback", d, 32'h9A5C_3E71);

    // R3 R4 command cycles over a sweep of write timings
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          wr_reg(A_TIM, mk(fv(a), fv(b), fv(c), 0, 0, 0, 0, 0));
          wr_reg(A_CMD, 32'hFFFF_FF00 | 32'(a * 16 + b * 4 + c));
          run_cycle(0, 1, 0, 8'(a * 16 + b * 4 + c), s, w, h, bad);
          chk("R3 setup len", s, fv(a) + 1);
          chk("R3 strobe len", w, fv(c) + 1);
          chk("R3 hold len", h, fv(b) + 1);
          chk("R4 cmd signals", bad, 0);
        end

    // R5 address cycle
    wr_reg(A_TIM, mk(2, 1, 3, 0, 0, 0, 0, 0));
    wr_reg(A_ADDR, 32'h0000_12C4);
    run_cycle(0, 0, 1, 8'hC4, s, w, h, bad);
    chk("R5 addr lens", {8'(s), 8'(w), 8'(h)}, {8'd3, 8'd4, 8'd2});
    chk("R5 addr signals", bad, 0);

    // R6 data write cycles
    for (int k = 0; k < 4; k++) begin
      wr_reg(A_TIM, mk(fv(k), fv(3 - k), 1, 0, 0, 0, 0, 0));
      wr_reg(A_DATA, 32'hABCD_0000 | 32'(8'h5A ^ k));
      run_cycle(0, 0, 0, 8'h5A ^ 8'(k), s, w, h, bad);
      chk("R6 wr lens", {8'(s), 8'(w), 8'(h)}, {8'(fv(k) + 1), 8'd2, 8'(fv(3 - k) + 1)});
      chk("R6 wr signals", bad, 0);
      chk("R6 dq held", nand_dq_out, 8'h5A ^ 8'(k));
    end

    // R7 read cycles over a sweep of read timings
    wr_reg(A_CFG, 32'h2);
    begin
      logic [7:0] prev;
      prev = 8'h00;
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 4; c++) begin
            logic [7:0] pat;
            pat = 8'(a * 37 + b * 11 + c * 5 + 9);
            wr_reg(A_TIM, mk(0, 0, 0, 0, fv(a), fv(b), fv(c), 0));
            nand_dq_in = pat;
            rd_reg(A_DATA, d);
            chk("R7 read return", d, 32'(prev));
            run_cycle(1, 0, 0, 8'h00, s, w, h, bad);
            chk("R7 setup len", s, fv(a) + 1);
            chk("R7 strobe len", w, fv(c) + 1);
            chk("R7 hold len", h, fv(b) + 1);
            chk("R7 rd signals", bad, 0);
            prev = pat;
          end
      nand_dq_in = 8'h00;
      rd_reg(A_DATA, d);
      chk("R7 last read return", d, 32'(prev));
      run_cycle(1, 0, 0, 8'h00, s, w, h, bad);
    end

    // R8 accesses during a cycle are ignored
    wr_reg(A_CFG, 32'h0);
    wr_reg(A_TIM, mk(15, 15, 15, 0, 0, 0, 0, 0));
    wr_reg(A_CMD, 32'h11);
    rd_reg(A_STAT, d);  chk("R8 busy bit", d[1], 1);
    wr_reg(A_CMD, 32'h22);
    wr_reg(A_ADDR, 32'h33);
    wr_reg(A_DATA, 32'h44);
    for (int i = 0; i < 100 && !nand_ce_n; i++) @(negedge clk);
    begin
      int low;
      low = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (!nand_ce_n) low++;
      end
      chk("R8 no extra cycle", low, 0);
    end
    chk("R8 dq unchanged", nand_dq_out, 8'h11);
    rd_reg(A_STAT, d);  chk("R8 idle bit", d[1], 0);

    // R9 chip-enable override
    wr_reg(A_CFG, 32'h20);
    chk("R9 forced ce", nand_ce_n, 0);
    rd_reg(A_CFG, d);  chk("R9 cfg read", d, 32'h20);
    wr_reg(A_CFG, 32'h0);
    chk("R9 released ce", nand_ce_n, 1);

    // R11 ready synchroniser
    nand_rdy = 1'b0;
    repeat (4) @(negedge clk);
    rd_reg(A_STAT, d);  chk("R11 busy pin", d[0], 0);
    nand_rdy = 1'b1;
    repeat (4) @(negedge clk);
    rd_reg(A_STAT, d);  chk("R11 ready pin", d[0], 1);

    // R12 ready event window
    nand_rdy = 1'b0;
    repeat (5) @(negedge clk);
    wr_reg(A_ICLR, 32'h3);
    wr_reg(A_TIM, mk(0, 0, 0, 15, 0, 0, 0, 0));
    wr_reg(A_CMD, 32'h70);
    run_cycle(0, 1, 0, 8'h70, s, w, h, bad);
    nand_rdy = 1'b1;
    repeat (40) @(negedge clk);
    rd_reg(A_IST, d);  chk("R12 rise in window ignored", d[0], 0);
    nand_rdy = 1'b0;
    repeat (6) @(negedge clk);
    nand_rdy = 1'b1;
    repeat (6) @(negedge clk);
    rd_reg(A_IST, d);  chk("R12 rise after window", d[0], 1);
    wr_reg(A_IEN, 32'h1);
    chk("R14 irq ready", irq, 1);
    wr_reg(A_ICLR, 32'h1);
    chk("R14 irq cleared", irq, 0);
    rd_reg(A_IST, d);  chk("R14 ist cleared", d, 0);
    nand_rdy = 1'b0;
    wr_reg(A_TIM, mk(0, 0, 0, 2, 0, 0, 0, 0));
    wr_reg(A_CMD, 32'h71);
    run_cycle(0, 1, 0, 8'h71, s, w, h, bad);
    repeat (20) @(negedge clk);
    nand_rdy = 1'b1;
    repeat (6) @(negedge clk);
    rd_reg(A_IST, d);  chk("R12 late rise event", d[0], 1);
    wr_reg(A_ICLR, 32'h1);
    wr_reg(A_IEN, 32'h0);

    // R13 transfer counter
    wr_reg(A_TIM, 32'h0);
    wr_reg(A_CNT, 32'd3);
    rd_reg(A_CNT, d);  chk("R13 load", d, 3);
    for (int k = 0; k < 2; k++) begin
      wr_reg(A_DATA, 32'(k));
      run_cycle(0, 0, 0, 8'(k), s, w, h, bad);
    end
    rd_reg(A_CNT, d);  chk("R13 after two", d, 1);
    rd_reg(A_IST, d);  chk("R13 not done yet", d[1], 0);
    wr_reg(A_DATA, 32'h2);
    run_cycle(0, 0, 0, 8'h2, s, w, h, bad);
    rd_reg(A_CNT, d);  chk("R13 at zero", d, 0);
    rd_reg(A_IST, d);  chk("R13 done bit", d[1], 1);
    wr_reg(A_DATA, 32'h3);
    run_cycle(0, 0, 0, 8'h3, s, w, h, bad);
    rd_reg(A_CNT, d);  chk("R13 stays zero", d, 0);

    // R14 enable masking and clearing
    chk("R14 masked irq", irq, 0);
    wr_reg(A_IEN, 32'h2);
    chk("R14 enabled irq", irq, 1);
    wr_reg(A_ICLR, 32'h2);
    chk("R14 cleared irq", irq, 0);

    // R10 software reset
    wr_reg(A_CFG, 32'h22);
    wr_reg(A_TIM, 32'hFFFF_FFFF);
    wr_reg(A_CNT, 32'd9);
    wr_reg(A_CTRL, 32'h4);
    chk("R10 ce_n", nand_ce_n, 1);
    rd_reg(A_CFG, d);  chk("R10 cfg", d, 0);
    rd_reg(A_TIM, d);  chk("R10 tim", d, 0);
    rd_reg(A_CNT, d);  chk("R10 cnt", d, 0);
    rd_reg(A_IEN, d);  chk("R10 ien", d, 0);
    rd_reg(A_CTRL, d); chk("R10 ctrl reads 0", d, 0);

    // R12 no event without a command after reset
    nand_rdy = 1'b0;
    repeat (5) @(negedge clk);
    nand_rdy = 1'b1;
    repeat (6) @(negedge clk);
    rd_reg(A_IST, d);  chk("R12 unarmed rise", d, 0);

    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule